// File: doc/BRIEF.md
# GPIO Port Register Bank

A memory-mapped general-purpose I/O port covering one bank of 32 pins. Software drives the output latch only through two write-only strobe registers, one that raises the latch bits written as 1 and one that lowers them, so no read-modify-write is ever needed to change a single pin. A direction register decides which pins drive their pad. A level register returns the live pad state after a two-flop synchroniser.

Each pin also owns a 2-bit function code, packed sixteen pins to a 32-bit word. Code 0 leaves the pin under GPIO control. Codes 1 to 3 hand the pad's output value and output enable to one of three peripheral sources, and the pin is then flagged as occupied. The latch can be preloaded while a pin is still an input. When the pin is later turned to output, it starts at a known level.

Register word addresses are: 0 level (read-only), 1 direction, 2 set strobe (write-only), 3 clear strobe (write-only), 4 function codes of pins 0–15, 5 function codes of pins 16–31. Addresses 6 and 7 are unmapped. Writes take effect at the rising clock edge. Read data is a combinational function of the address and current state.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every direction bit, output latch bit and function code is 0. So pad_oe_o, pad_out_o and occupied_o are all 0, and the direction and both function words read as 0.
- R2: A write to address 2 sets each latch bit whose data bit is 1 at that clock edge. Bits written as 0 keep their value.
- R3: A write to address 3 clears each latch bit whose data bit is 1 at that clock edge. Bits written as 0 keep their value.
- R4: A write to address 1 loads the direction register, where bit n = 1 makes pin n an output. It reads back unchanged and, for pins with function code 0, appears on pad_oe_o after the edge.
- R5: Reading address 0 returns pad_in_i delayed by two rising clock edges. A change applied before one edge is not yet visible after that edge, and is visible after the second.
- R6: The function code of pin p is held in word 4 + p/16, at bits (p mod 16)*2+1 : (p mod 16)*2. Both words read back as written.
- R7: A pin with a non-zero function code k shows 1 on occupied_o. Its pad_out_o and pad_oe_o come from alt_out_i[k-1] and alt_oe_i[k-1]. A pin with code 0 uses its latch and direction bits and shows 0 on occupied_o.
- R8: The output latch drives pad_out_o whatever the direction bit is. A level preset while the pin is an input is therefore the level it drives from the edge at which its direction bit turns to 1.
- R9: Reads of addresses 2, 3, 6 and 7 return 0. Writes to addresses 0, 6 and 7 change no direction, latch or function state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the current address |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| pad_in_i | input | 32 | Pad input levels (asynchronous) |
| pad_out_o | output | 32 | Pad output values |
| pad_oe_o | output | 32 | Pad output enables |
| alt_out_i | input | 3x32 | Output values of peripheral sources 1..3 |
| alt_oe_i | input | 3x32 | Output enables of peripheral sources 1..3 |
| occupied_o | output | 32 | Pin is owned by a peripheral (non-zero function code) |

## Verification
The assertions assume that pad_in_i comes from asynchronous pads, so they only relate the level register to inputs sampled two edges earlier. They start checking only after two cycles out of reset. They also assume that only one register is written per cycle, because the interface has a single address. The bench keeps to this: it changes pad_in_i, addr_i, wdata_i and we_i only on falling edges, issues a single write at a time, and waits for the synchroniser depth before it compares level reads.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned ADDR_W = 3;

  // word addresses; function-code words follow FSEL_BASE contiguously
  localparam logic [ADDR_W-1:0] A_LEVEL     = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIR       = 3'd1;
  localparam logic [ADDR_W-1:0] A_SET       = 3'd2;
  localparam logic [ADDR_W-1:0] A_CLR       = 3'd3;
  localparam logic [ADDR_W-1:0] A_FSEL_BASE = 3'd4;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned FN_W     = 2,
  localparam int unsigned PPW        = NUM_PINS / FN_W,
  localparam int unsigned FSEL_WORDS = (NUM_PINS * FN_W) / NUM_PINS
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               we_i,
  input  logic [ADDR_W-1:0]                  addr_i,
  input  logic [NUM_PINS-1:0]                wdata_i,
  input  logic [NUM_PINS-1:0]                level_i,
  output logic [NUM_PINS-1:0]                rdata_o,
  output logic [NUM_PINS-1:0]                dir_o,
  output logic [NUM_PINS-1:0]                latch_o,
  output logic [NUM_PINS-1:0][FN_W-1:0]      fsel_o
);
  logic [NUM_PINS-1:0] dir_q, latch_q;
  logic [FSEL_WORDS-1:0][NUM_PINS-1:0] fsel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '0;
      latch_q <= '0;
    end else if (we_i) begin
      if (addr_i == A_DIR) dir_q <= wdata_i;
      if (addr_i == A_SET) latch_q <= latch_q | wdata_i;
      if (addr_i == A_CLR) latch_q <= latch_q & ~wdata_i;
    end
  end

  for (genvar w = 0; w < FSEL_WORDS; w++) begin : g_fsel_word
    localparam logic [ADDR_W-1:0] WADDR = A_FSEL_BASE + ADDR_W'(w);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fsel_q[w] <= '0;
      else if (we_i && addr_i == WADDR) fsel_q[w] <= wdata_i;
    end
  end

  // pin p: word p/PPW, field at (p mod PPW)*FN_W
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_unpack
    assign fsel_o[p] = fsel_q[p / PPW][(p % PPW) * FN_W +: FN_W];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_LEVEL) rdata_o = level_i;
    if (addr_i == A_DIR)   rdata_o = dir_q;
    for (int w = 0; w < int'(FSEL_WORDS); w++) begin
      if (addr_i == A_FSEL_BASE + ADDR_W'(w)) rdata_o = fsel_q[w];
    end
  end

  assign dir_o   = dir_q;
  assign latch_o = latch_q;
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned FN_W     = 2,
  localparam int unsigned NUM_ALT = (1 << FN_W) - 1
) (
  input  logic [NUM_PINS-1:0]               latch_i,
  input  logic [NUM_PINS-1:0]               dir_i,
  input  logic [NUM_PINS-1:0][FN_W-1:0]     fsel_i,
  input  logic [NUM_ALT-1:0][NUM_PINS-1:0]  alt_out_i,
  input  logic [NUM_ALT-1:0][NUM_PINS-1:0]  alt_oe_i,
  output logic [NUM_PINS-1:0]               pad_out_o,
  output logic [NUM_PINS-1:0]               pad_oe_o,
  output logic [NUM_PINS-1:0]               occupied_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_comb begin
      pad_out_o[p] = latch_i[p];
      pad_oe_o[p]  = dir_i[p];
      for (int k = 1; k <= int'(NUM_ALT); k++) begin
        if (fsel_i[p] == FN_W'(k)) begin
          pad_out_o[p] = alt_out_i[k-1][p];
          pad_oe_o[p]  = alt_oe_i[k-1][p];
        end
      end
    end
    assign occupied_o[p] = |fsel_i[p];
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned FN_W     = 2,
  parameter int unsigned SYNC_N   = 2,
  localparam int unsigned NUM_ALT = (1 << FN_W) - 1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [NUM_PINS-1:0]               wdata_i,
  output logic [NUM_PINS-1:0]               rdata_o,
  input  logic [NUM_PINS-1:0]               pad_in_i,
  output logic [NUM_PINS-1:0]               pad_out_o,
  output logic [NUM_PINS-1:0]               pad_oe_o,
  input  logic [NUM_ALT-1:0][NUM_PINS-1:0]  alt_out_i,
  input  logic [NUM_ALT-1:0][NUM_PINS-1:0]  alt_oe_i,
  output logic [NUM_PINS-1:0]               occupied_o
);
  logic [NUM_PINS-1:0]           level_q, dir_q, latch_q;
  logic [NUM_PINS-1:0][FN_W-1:0] fsel_q;

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (level_q)
  );

  gpio_regs #(.NUM_PINS(NUM_PINS), .FN_W(FN_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .level_i(level_q),
    .rdata_o(rdata_o),
    .dir_o  (dir_q),
    .latch_o(latch_q),
    .fsel_o (fsel_q)
  );

  gpio_pad_mux #(.NUM_PINS(NUM_PINS), .FN_W(FN_W)) u_mux (
    .latch_i   (latch_q),
    .dir_i     (dir_q),
    .fsel_i    (fsel_q),
    .alt_out_i (alt_out_i),
    .alt_oe_i  (alt_oe_i),
    .pad_out_o (pad_out_o),
    .pad_oe_o  (pad_oe_o),
    .occupied_o(occupied_o)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned FN_W     = 2
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          we_i,
  input logic [ADDR_W-1:0]             addr_i,
  input logic [NUM_PINS-1:0]           wdata_i,
  input logic [NUM_PINS-1:0]           rdata_o,
  input logic [NUM_PINS-1:0]           pad_in_i,
  input logic [NUM_PINS-1:0]           pad_oe_o,
  input logic [NUM_PINS-1:0]           occupied_o,
  input logic [NUM_PINS-1:0]           level_q,
  input logic [NUM_PINS-1:0]           dir_q,
  input logic [NUM_PINS-1:0]           latch_q
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (cyc_q != 2'd2) cyc_q <= cyc_q + 2'd1;
  end

  a_r2_set_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_SET) |=> ((latch_q & $past(wdata_i)) == $past(wdata_i)));

  a_r2_set_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_SET) |=>
      ((latch_q & ~$past(wdata_i)) == ($past(latch_q) & ~$past(wdata_i))));

  a_r3_clr_lowers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_CLR) |=> ((latch_q & $past(wdata_i)) == '0));

  a_r3_clr_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_CLR) |=>
      ((latch_q & ~$past(wdata_i)) == ($past(latch_q) & ~$past(wdata_i))));

  a_r4_dir_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == A_DIR) |=> $stable(dir_q));

  a_r5_sync_depth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd2) |-> (level_q == $past(pad_in_i, 2)));

  a_r7_gpio_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o & ~occupied_o) == (dir_q & ~occupied_o)));

  a_r9_strobe_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_SET || addr_i == A_CLR) |-> (rdata_o == '0));

  a_r9_level_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_LEVEL) |=> ($stable(latch_q) && $stable(dir_q)));
endmodule

bind gpio_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS), .FN_W(FN_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .pad_in_i  (pad_in_i),
  .pad_oe_o  (pad_oe_o),
  .occupied_o(occupied_o),
  .level_q   (level_q),
  .dir_q     (dir_q),
  .latch_q   (latch_q)
);

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
module sim_gpio_bank;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             we = 1'b0;
  logic [2:0]       addr = '0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata;
  logic [31:0]      pad_in = '0;
  logic [31:0]      pad_out, pad_oe, occupied;
  logic [2:0][31:0] alt_out = '0;
  logic [2:0][31:0] alt_oe = '0;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  gpio_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .alt_out_i(alt_out), .alt_oe_i(alt_oe), .occupied_o(occupied)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_out", pad_out, 32'h0);
    check("R1 occupied", occupied, 32'h0);
    rd(3'd1, d); check("R1 dir", d, 32'h0);
    rd(3'd4, d); check("R1 fsel0", d, 32'h0);
    rd(3'd5, d); check("R1 fsel1", d, 32'h0);
  endtask

  task automatic t_set_clear;
    wr(3'd2, 32'h0000_00F0); check("R2 set", pad_out, 32'h0000_00F0);
    wr(3'd2, 32'h0000_0F00); check("R2 set keeps others", pad_out, 32'h0000_0FF0);
    wr(3'd3, 32'h0000_0030); check("R3 clear", pad_out, 32'h0000_0FC0);
    wr(3'd3, 32'h0000_0000); check("R3 clear zero no effect", pad_out, 32'h0000_0FC0);
    check("R2 R3 oe stays input", pad_oe, 32'h0);
  endtask

  task automatic t_preset;
    logic [31:0] d;
    wr(3'd2, 32'h8000_0000);
    check("R8 preset visible", pad_out, 32'h8000_0FC0);
    check("R8 still input", pad_oe, 32'h0);
    wr(3'd1, 32'h8000_0001);
    check("R8 drives preset", pad_oe & pad_out, 32'h8000_0000);
    check("R4 oe follows dir", pad_oe, 32'h8000_0001);
    rd(3'd1, d); check("R4 dir readback", d, 32'h8000_0001);
    wr(3'd1, 32'hA5A5_0000);
    rd(3'd1, d); check("R4 dir readback 2", d, 32'hA5A5_0000);
    check("R4 oe 2", pad_oe, 32'hA5A5_0000);
  endtask

  task automatic t_level;
    logic [31:0] pats [2] = '{32'h1234_5678, 32'hFEDC_0001};
    logic [31:0] prev = '0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      addr = 3'd0; pad_in = pats[i];
      @(negedge clk); #1 check("R5 one edge old", rdata, prev);
      @(negedge clk); #1 check("R5 two edges new", rdata, pats[i]);
      prev = pats[i];
    end
  endtask

  task automatic t_fsel;
    logic [31:0] d;
    wr(3'd2, 32'h0010_0000);                 // latch bit 20 high
    alt_out[0] = '1; alt_oe[0] = '1;
    alt_out[1] = 32'h0000_0008; alt_oe[1] = 32'h0000_0008;
    alt_out[2] = 32'h0;         alt_oe[2] = 32'h0010_0000;
    wr(3'd4, 32'h0000_0080);                 // pin 3 code 2
    wr(3'd5, 32'h0000_0300);                 // pin 20 code 3
    rd(3'd4, d); check("R6 fsel0 readback", d, 32'h0000_0080);
    rd(3'd5, d); check("R6 fsel1 readback", d, 32'h0000_0300);
    check("R7 occupied", occupied, 32'h0010_0008);
    check("R7 alt out", pad_out & 32'h0010_0008, 32'h0000_0008);
    check("R7 alt oe", pad_oe & 32'h0010_0008, 32'h0010_0008);
    check("R7 gpio pins keep dir", pad_oe & ~32'h0010_0008, 32'hA5A5_0000 & ~32'h0010_0008);
    wr(3'd5, 32'h0);
    wr(3'd4, 32'h0);
    check("R7 released", occupied, 32'h0);
    check("R7 back to latch", pad_out & 32'h0010_0008, 32'h0010_0000);
  endtask

  task automatic t_zero;
    logic [31:0] d, out0, oe0;
    rd(3'd2, d); check("R9 read set", d, 32'h0);
    rd(3'd3, d); check("R9 read clr", d, 32'h0);
    rd(3'd6, d); check("R9 read 6", d, 32'h0);
    rd(3'd7, d); check("R9 read 7", d, 32'h0);
    out0 = pad_out; oe0 = pad_oe;
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    check("R9 write ignored out", pad_out, out0);
    check("R9 write ignored oe", pad_oe, oe0);
    check("R9 write ignored occ", occupied, 32'h0);
    rd(3'd1, d); check("R9 dir intact", d, 32'hA5A5_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_set_clear();
    t_preset();
    t_level();
    t_fsel();
    t_zero();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule